// File: doc/BRIEF.md
# Grouped External Interrupt Controller

The controller samples 28 external interrupt pins. Each pin passes through a synchroniser and is then judged against a trigger condition. Pins 2k and 2k+1 share one trigger condition. A line that meets its condition sets its pending bit. Software clears a pending bit by writing a one to it. A per-line mask decides whether a pending bit reaches the outputs. The unmasked pending bits are folded into four registered group lines of unequal span (4, 8, 8 and 8 lines), which drive an upstream interrupt controller.

Software uses a plain single-cycle port: a write strobe, a 4-bit word address and 32-bit write data. Read data is combinational from the address. The port carries no streaming traffic, so it has no valid/ready handshake: every write is taken on the clock edge where the strobe is high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask word reads 0x0FFFFFFF (all lines masked), the pending word and both trigger words read 0, and every group output is 0. The synchroniser and edge history reset to 1, so pins that are held high raise nothing after reset.
- R2: Word address 0 holds the trigger word for lines 0-15, address 1 the trigger word for lines 16-27, address 2 the mask and address 3 the pending word. Any other address reads 0, and a write to it changes nothing.
- R3: Lines 2k and 2k+1 share a 3-bit trigger field at bits [(j/2)*4 +: 3] of their word, where j is the line's index within that word. Bit 3 of every nibble reads 0. In the second word, bits 31:24 belong to lines above 27: they read 0 and writes to them are dropped. Bits 31:28 of the mask and pending words read 0.
- R4: Field 3'b000 is low level and 3'b001 is high level. In a level mode the pending bit is set in every cycle in which the synchronised pin sits at the active level.
- R5: Field 3'b01x is falling edge, 3'b10x is rising edge and 3'b11x is both edges. An edge is a difference between the current and the previous synchronised value.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: When a trigger event and a clearing write hit the same line in the same cycle, the bit stays set. A level line that is still active therefore cannot be cleared.
- R8: A mask bit of 1 keeps its pending bit off every group output but does not stop the bit from being recorded. Clearing the mask bit lets a pending bit that is already set reach its group on the next edge.
- R9: Group 0 covers lines 0-3, group 1 lines 4-11, group 2 lines 12-19 and group 3 lines 20-27. Each group is high when any unmasked pending bit in its range is set.
- R10: A pin change sets its pending bit on the third rising clock edge after the change. The group output follows on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pins_i | input | 28 | External interrupt pins, asynchronous to clk |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Word address for reads and writes |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Combinational read data for cfg_addr_i |
| grp_irq_o | output | 4 | Registered group interrupt outputs |

## Verification
A trigger event and a software clear can land on the same pending bit in the same cycle. In edge mode the bench times a rising pin so that its edge reaches the detector exactly when a write-one-to-clear to that bit is strobed. It then expects the bit to read back as set, and to clear on a later write. In level mode the bench writes the clear while the pin is still active and expects the bit to stay set. The same clear, issued after the pin drops, must take effect.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int TRIG_W = 3;
  localparam int NIB_W  = 4;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TRIG_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_TRIG_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 4'd2;
  localparam logic [ADDR_W-1:0] A_PEND    = 4'd3;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic fall;
    logic rise;
  } trig_t;

  function automatic trig_t trig_decode(input logic [TRIG_W-1:0] f);
    trig_t t;
    t.lvl_lo = (f == 3'b000);
    t.lvl_hi = (f == 3'b001);
    t.fall   = f[1];
    t.rise   = f[2];
    return t;
  endfunction

  // Writable bits of a trigger word whose first line is 'base'.
  function automatic logic [WORD_W-1:0] trig_wmask(input int base, input int lines);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < WORD_W / NIB_W; k++) begin
      if (base + 2 * k < lines) m[k*NIB_W +: TRIG_W] = '1;
    end
    return m;
  endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/eic_trig.sv
module eic_trig
  import eic_pkg::*;
#(
  parameter int N = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              sync_i,
  input  logic [N-1:0][TRIG_W-1:0]  line_cfg_i,
  output logic [N-1:0]              event_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    trig_t t;
    always_comb begin
      t = trig_decode(line_cfg_i[i]);
      event_o[i] = (t.lvl_lo & ~sync_i[i])
                 | (t.lvl_hi &  sync_i[i])
                 | (t.fall   &  prev_q[i] & ~sync_i[i])
                 | (t.rise   & ~prev_q[i] &  sync_i[i]);
    end
  end
endmodule

// File: rtl/eic_group.sv
module eic_group #(
  parameter int N       = 28,
  parameter int FIRST_W = 4,
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       pend_i,
  input  logic [N-1:0]       mask_i,
  output logic [NUM_GRP-1:0] grp_o
);
  logic [N-1:0] live;
  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = (g == 0) ? 0 : FIRST_W + (g - 1) * GRP_W;
    localparam int HI = (g == 0) ? FIRST_W - 1 : LO + GRP_W - 1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_o[g] <= 1'b0;
      else        grp_o[g] <= |live[HI:LO];
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES     = 28,
  parameter int LINES_PER_REG = 16,
  parameter int FIRST_GRP_W   = 4,
  parameter int GRP_W         = 8,
  parameter int NUM_GRP       = 1 + (NUM_LINES - FIRST_GRP_W) / GRP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LINES-1:0] ext_pins_i,
  input  logic               cfg_wr_i,
  input  logic [3:0]         cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  output logic [NUM_GRP-1:0] grp_irq_o
);
  localparam logic [WORD_W-1:0] WM_LO = trig_wmask(0, NUM_LINES);
  localparam logic [WORD_W-1:0] WM_HI = trig_wmask(LINES_PER_REG, NUM_LINES);

  logic [WORD_W-1:0]    trig_lo_q, trig_hi_q;
  logic [NUM_LINES-1:0] mask_q, pend_q, clr_vec, set_vec, sync_pins;
  logic [NUM_LINES-1:0][TRIG_W-1:0] line_cfg;

  eic_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_pins_i), .q_o(sync_pins)
  );

  // Per-line trigger field extraction: pair (2k,2k+1) shares a nibble.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
    localparam int LOC = i % LINES_PER_REG;
    localparam int OFF = (LOC / 2) * NIB_W;
    if (i < LINES_PER_REG) begin : g_lo
      assign line_cfg[i] = trig_lo_q[OFF +: TRIG_W];
    end else begin : g_hi
      assign line_cfg[i] = trig_hi_q[OFF +: TRIG_W];
    end
  end

  eic_trig #(.N(NUM_LINES)) u_trig (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_pins),
    .line_cfg_i(line_cfg), .event_o(set_vec)
  );

  assign clr_vec = (cfg_wr_i && cfg_addr_i == A_PEND) ? cfg_wdata_i[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      mask_q    <= '1;
      pend_q    <= '0;
    end else begin
      if (cfg_wr_i && cfg_addr_i == A_TRIG_LO) trig_lo_q <= cfg_wdata_i & WM_LO;
      if (cfg_wr_i && cfg_addr_i == A_TRIG_HI) trig_hi_q <= cfg_wdata_i & WM_HI;
      if (cfg_wr_i && cfg_addr_i == A_MASK)    mask_q    <= cfg_wdata_i[NUM_LINES-1:0];
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      A_TRIG_LO: cfg_rdata_o = trig_lo_q;
      A_TRIG_HI: cfg_rdata_o = trig_hi_q;
      A_MASK:    cfg_rdata_o = WORD_W'(mask_q);
      A_PEND:    cfg_rdata_o = WORD_W'(pend_q);
      default:   cfg_rdata_o = '0;
    endcase
  end

  eic_group #(
    .N(NUM_LINES), .FIRST_W(FIRST_GRP_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)
  ) u_group (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_q), .mask_i(mask_q), .grp_o(grp_irq_o)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int N  = 28,
  parameter int NG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [3:0]    addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  set_vec,
  input logic [NG-1:0] grp
);
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R7

  AST_W1C_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'd3) |=> ((pend_q & $past(wdata[N-1:0]) & ~$past(set_vec)) == '0)); // R6

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0)); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0) |=> (grp == '0)); // R8

  AST_GRP0_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q[3:0] & ~mask_q[3:0]) != '0) |=> grp[0]); // R10

  AST_HI_FIELDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd1) |-> (rdata[31:24] == 8'h00)); // R3
endmodule

bind ext_irq_ctrl eic_checker #(.N(NUM_LINES), .NG(NUM_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i),
  .wdata(cfg_wdata_i), .rdata(cfg_rdata_o), .mask_q(mask_q),
  .pend_q(pend_q), .set_vec(set_vec), .grp(grp_irq_o)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins = '1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pins_i(pins), .cfg_wr_i(wr_en),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .grp_irq_o(grp)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 trig lo reset", v, 32'h0);
    rd(1, v); chk("R1 trig hi reset", v, 32'h0);
    rd(2, v); chk("R1 mask reset", v, 32'h0FFFFFFF);
    rd(3, v); chk("R1 pending reset", v, 32'h0);
    chk("R1 groups reset", 32'(grp), 32'h0);
    wait_cyc(4);
    rd(3, v); chk("R1 no pending after reset with pins high", v, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(0, 32'hFFFFFFFF); rd(0, v); chk("R3 trig lo nibble top bits", v, 32'h77777777);
    wr(1, 32'hFFFFFFFF); rd(1, v); chk("R3 trig hi lines above 27", v, 32'h00777777);
    wr(5, 32'hDEADBEEF); rd(5, v); chk("R2 unmapped reads zero", v, 32'h0);
    rd(0, v); chk("R2 unmapped write no effect", v, 32'h77777777);
    wr(2, 32'hFFFFFFFF); rd(2, v); chk("R3 mask top bits", v, 32'h0FFFFFFF);
    wr(0, 32'h44444444); wr(1, 32'h00444444);
    rd(1, v); chk("R2 trig hi rising baseline", v, 32'h00444444);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pins[6] = 1'b0; wait_cyc(4);
    rd(3, v); chk("R5 rising ignores fall", v, 32'h0);
    wr(0, 32'h44440444); wait_cyc(3);
    rd(3, v); chk("R4 low level sets only low pin", v, 32'h40);
    wr(3, 32'h40);
    rd(3, v); chk("R7 level clear while active", v, 32'h40);
    wr(0, 32'h44441444); wait_cyc(2);
    wr(3, 32'hC0);
    rd(3, v); chk("R3 pair shares high level field", v, 32'h80);
    wr(0, 32'h44444444); wait_cyc(1);
    pins[6] = 1'b1; wait_cyc(4);
    rd(3, v); chk("R5 rising sets", v, 32'hC0);
    wr(3, 32'hFF);
    rd(3, v); chk("R6 clear inactive lines", v, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(1, 32'h00444244);
    pins[20] = 1'b0; wait_cyc(4);
    rd(3, v); chk("R5 falling sets", v, 32'h00100000);
    wr(3, 32'h00100000);
    pins[20] = 1'b1; wait_cyc(4);
    rd(3, v); chk("R5 falling ignores rise", v, 32'h0);
    wr(1, 32'h00444644);
    pins[20] = 1'b0; wait_cyc(4);
    rd(3, v); chk("R5 both edges fall", v, 32'h00100000);
    wr(3, 32'h00100000);
    pins[20] = 1'b1; wait_cyc(4);
    rd(3, v); chk("R5 both edges rise", v, 32'h00100000);
    wr(3, 32'h00100000);
    wr(1, 32'h00444444);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pins[13] = 1'b0; wait_cyc(4);
    wr(3, 32'h2000);
    rd(3, v); chk("R6 pending clear before collision", v, 32'h0);
    pins[13] = 1'b1; wait_cyc(2);
    wr(3, 32'h2000);
    rd(3, v); chk("R7 edge set wins same cycle clear", v, 32'h2000);
    wr(3, 32'h0);
    rd(3, v); chk("R6 write zero keeps bit", v, 32'h2000);
    wr(3, 32'h2000);
    rd(3, v); chk("R6 write one clears", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pins[2] = 1'b0; pins[11] = 1'b0; wait_cyc(4);
    pins[2] = 1'b1; pins[11] = 1'b1; wait_cyc(5);
    rd(3, v); chk("R8 masked bits still recorded", v, 32'h00000804);
    chk("R8 masked groups low", 32'(grp), 32'h0);
    wr(2, 32'h0FFFF7FF); wait_cyc(1);
    chk("R8 unmask line 11 raises group 1", 32'(grp), 32'h2);
    wr(2, 32'h0); wait_cyc(1);
    chk("R9 lines 2 and 11 groups", 32'(grp), 32'h3);
    wr(3, 32'hFFFFFFFF); wait_cyc(1);
    chk("R6 clear all drops groups", 32'(grp), 32'h0);
  endtask

  task automatic t_groups();
    int lines [8] = '{0, 3, 4, 11, 12, 19, 20, 27};
    int gexp  [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    for (int k = 0; k < 8; k++) begin
      pins[lines[k]] = 1'b0; wait_cyc(4);
      pins[lines[k]] = 1'b1; wait_cyc(5);
      chk($sformatf("R9 line %0d group", lines[k]), 32'(grp), 32'(1 << gexp[k]));
      wr(3, 32'hFFFFFFFF); wait_cyc(1);
      chk("R9 group drops after clear", 32'(grp), 32'h0);
    end
  endtask

  task automatic t_latency();
    logic [31:0] v;
    pins[0] = 1'b0; wait_cyc(4);
    wr(3, 32'hFFFFFFFF); wait_cyc(1);
    pins[0] = 1'b1; wait_cyc(2);
    rd(3, v); chk("R10 not pending after two edges", v, 32'h0);
    wait_cyc(1);
    rd(3, v); chk("R10 pending on third edge", v, 32'h1);
    chk("R10 group not yet", 32'(grp), 32'h0);
    wait_cyc(1);
    chk("R10 group on fourth edge", 32'(grp), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_level();
    t_edges();
    t_collision();
    t_mask();
    t_groups();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule